// File: doc/BRIEF.md
# Coherence Miss Sharing Classifier

This block sits beside a private cache and keeps, for every cache line, the bookkeeping needed to decide whether a coherence miss was caused by true data sharing or by false sharing. A coherence miss is a miss where the tag still matches but the line has lost its permission. When one occurs, the block asks an external history table which words of the line other cores wrote or read in the meantime. It then watches every access the local core makes to the line for as long as the line stays resident.

The verdict is not given when the miss happens. A miss starts out as false sharing and becomes true sharing as soon as any access in the residency touches a word that another core produced, or, for a write, a word that another core consumed. When the line is invalidated, downgraded or replaced, the block sends the local read and write word masks back to the history table. If the residency began with a coherence miss, it also emits one classification record that holds the PC of the missing access and the false-sharing verdict.

Top module: `shc_top`

## Requirements
- R1: After synchronous reset, `rec_valid`, `push_valid`, `hq_req_valid` and `acc_busy` are low and `ev_ready` is high.
- R2: `acc_state` encodes 2'b00 hit, 2'b01 tag present but invalid, 2'b10 tag present read-only, 2'b11 refill after a non-coherence miss. A read is a coherence miss only in state 2'b01. A write is a coherence miss in states 2'b01 and 2'b10. No other access issues a history query.
- R3: An accepted coherence miss raises `hq_req_valid` for exactly one cycle, in the cycle after acceptance, with `hq_req_line` set to the line. `acc_busy` is high for accesses to that line, and for any further coherence miss, until `hq_rsp_valid` is seen. The response may arrive in the request cycle or later.
- R4: The record carries the PC of the access that caused the coherence miss.
- R5: A write to word k during a classified residency makes the miss true sharing when bit k of either the written-by-others mask or the read-by-others mask is set. This check includes the write that missed.
- R6: A read of word k makes the miss true sharing only when bit k of the written-by-others mask is set. A read of a word that others only read leaves the miss as false sharing.
- R7: The checks of R5 and R6 apply to every access from the miss until the line leaves. Once the miss is true sharing, it stays true sharing.
- R8: A write to word k sets local-write bit k and clears local-read bit k. A read sets local-read bit k. One cycle after an eviction is accepted, `push_valid` is high for one cycle with `push_line` and both local masks.
- R9: A record is emitted only when the evicted residency began with a coherence miss. Any other eviction pushes the masks and raises no record.
- R10: A record stays on `rec_valid`/`rec_pc`/`rec_false` unchanged until `rec_ready` is high. While a record is held, `ev_ready` is low.
- R11: An eviction, and a refill access (state 2'b11), clear every mask and flag of the line. A later eviction of the line then pushes zero masks, apart from the refill access itself, and raises no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Local access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_line | input | LINE_W | Cache line index |
| acc_word | input | WORD_W | Word offset in the line |
| acc_pc | input | PC_W | PC of the access |
| acc_state | input | 2 | Lookup result encoding (R2) |
| acc_busy | output | 1 | Access stalled, retry later |
| hq_req_valid | output | 1 | History query pulse |
| hq_req_line | output | LINE_W | Line of the history query |
| hq_rsp_valid | input | 1 | History response present |
| hq_rsp_wr_oth | input | WORDS | Words written by other cores |
| hq_rsp_rd_oth | input | WORDS | Words read by other cores |
| ev_valid | input | 1 | Line leaves (invalidate, downgrade, replace) |
| ev_line | input | LINE_W | Line index of the eviction |
| ev_ready | output | 1 | Eviction can be accepted |
| push_valid | output | 1 | Local masks for the history table |
| push_line | output | LINE_W | Line of the pushed masks |
| push_loc_wr | output | WORDS | Words written locally |
| push_loc_rd | output | WORDS | Words read locally since last local write |
| rec_valid | output | 1 | Classification record present |
| rec_ready | input | 1 | Record accepted |
| rec_pc | output | PC_W | PC of the missing access |
| rec_false | output | 1 | 1 = false sharing, 0 = true sharing |

## Verification
The hardest case to reach is a verdict that flips after the miss, on a later hit to a different word of the same line. It needs a history response whose masks leave the missing word clean but mark a neighbour as produced elsewhere. The stimulus sets up this exact pair of masks and then hits the neighbour before evicting. A second hard case is a refill that erases a pending classification. A line first takes a coherence miss, and then a refill access arrives before the eviction, which must then push only the refill's own word and no record.

// File: rtl/shc_pkg.sv
package shc_pkg;

    parameter int unsigned WORDS = 16;
    parameter int unsigned PC_W  = 16;
    localparam int unsigned WORD_W = $clog2(WORDS);

    typedef logic [WORDS-1:0]  wmask_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PC_W-1:0]   pc_t;

    typedef enum logic [1:0] {
        ST_HIT  = 2'b00,
        ST_INV  = 2'b01,
        ST_RO   = 2'b10,
        ST_FILL = 2'b11
    } acc_state_e;

    typedef struct packed {
        wmask_t wr_oth;
        wmask_t rd_oth;
        wmask_t loc_wr;
        wmask_t loc_rd;
        pc_t    pc;
        logic   coh;
        logic   fs;
    } line_st_t;

    function automatic line_st_t idle_line();
        line_st_t s;
        s     = '0;
        s.fs  = 1'b1;
        return s;
    endfunction

    function automatic logic is_coh_miss(logic wr, acc_state_e st);
        if (wr) return (st == ST_INV) || (st == ST_RO);
        return st == ST_INV;
    endfunction

    function automatic line_st_t apply_acc(line_st_t s, logic wr, word_t w);
        line_st_t r;
        r = s;
        if (s.coh && s.fs) begin
            if (wr) begin
                if (s.wr_oth[w] || s.rd_oth[w]) r.fs = 1'b0;
            end else if (s.wr_oth[w]) begin
                r.fs = 1'b0;
            end
        end
        if (wr) begin
            r.loc_wr[w] = 1'b1;
            r.loc_rd[w] = 1'b0;
        end else begin
            r.loc_rd[w] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/shc_line_bank.sv
module shc_line_bank
    import shc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [LINE_W-1:0] upd_idx,
    input  line_st_t          upd_data,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_idx,
    input  line_st_t          fill_data,
    input  logic              clr_en,
    input  logic [LINE_W-1:0] clr_idx,
    input  logic [LINE_W-1:0] rd_a_idx,
    input  logic [LINE_W-1:0] rd_b_idx,
    input  logic [LINE_W-1:0] rd_c_idx,
    output line_st_t          rd_a,
    output line_st_t          rd_b,
    output line_st_t          rd_c
);

    line_st_t mem [NUM_LINES];

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            line_st_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= idle_line();
                end else if (clr_en && clr_idx == LINE_W'(i)) begin
                    q <= idle_line();
                end else if (fill_en && fill_idx == LINE_W'(i)) begin
                    q <= fill_data;
                end else if (upd_en && upd_idx == LINE_W'(i)) begin
                    q <= upd_data;
                end
            end
            assign mem[i] = q;
        end
    endgenerate

    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];
    assign rd_c = mem[rd_c_idx];

endmodule

// File: rtl/shc_query_track.sv
module shc_query_track
    import shc_pkg::*;
#(
    parameter int unsigned LINE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINE_W-1:0] start_line,
    input  logic              start_wr,
    input  word_t             start_word,
    input  pc_t               start_pc,
    input  logic              rsp_valid,
    output logic              pend_valid,
    output logic [LINE_W-1:0] pend_line,
    output logic              pend_wr,
    output word_t             pend_word,
    output pc_t               pend_pc,
    output logic              req_valid,
    output logic              done
);

    assign done = pend_valid && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            req_valid  <= 1'b0;
            pend_line  <= '0;
            pend_wr    <= 1'b0;
            pend_word  <= '0;
            pend_pc    <= '0;
        end else begin
            req_valid <= start;
            if (start) begin
                pend_valid <= 1'b1;
                pend_line  <= start_line;
                pend_wr    <= start_wr;
                pend_word  <= start_word;
                pend_pc    <= start_pc;
            end else if (done) begin
                pend_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/shc_rec_buf.sv
module shc_rec_buf
    import shc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  pc_t  load_pc,
    input  logic load_fs,
    input  logic rec_ready,
    output logic rec_valid,
    output pc_t  rec_pc,
    output logic rec_false
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid <= 1'b0;
            rec_pc    <= '0;
            rec_false <= 1'b0;
        end else if (load) begin
            rec_valid <= 1'b1;
            rec_pc    <= load_pc;
            rec_false <= load_fs;
        end else if (rec_ready) begin
            rec_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/shc_top.sv
module shc_top
    import shc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [LINE_W-1:0] acc_line,
    input  logic [WORD_W-1:0] acc_word,
    input  logic [PC_W-1:0]   acc_pc,
    input  logic [1:0]        acc_state,
    output logic              acc_busy,
    output logic              hq_req_valid,
    output logic [LINE_W-1:0] hq_req_line,
    input  logic              hq_rsp_valid,
    input  logic [WORDS-1:0]  hq_rsp_wr_oth,
    input  logic [WORDS-1:0]  hq_rsp_rd_oth,
    input  logic              ev_valid,
    input  logic [LINE_W-1:0] ev_line,
    output logic              ev_ready,
    output logic              push_valid,
    output logic [LINE_W-1:0] push_line,
    output logic [WORDS-1:0]  push_loc_wr,
    output logic [WORDS-1:0]  push_loc_rd,
    output logic              rec_valid,
    input  logic              rec_ready,
    output logic [PC_W-1:0]   rec_pc,
    output logic              rec_false
);

    acc_state_e        st;
    logic              cm, acc_go, start, upd_en, ev_go, rec_load;
    logic              pend_valid, pend_wr, q_done;
    logic [LINE_W-1:0] pend_line;
    word_t             pend_word;
    pc_t               pend_pc;
    line_st_t          rd_acc, rd_pend, rd_ev, upd_data, fill_base, fill_data;

    assign st       = acc_state_e'(acc_state);
    assign cm       = is_coh_miss(acc_write, st);
    assign acc_busy = (pend_valid && (acc_line == pend_line || cm))
                   || (ev_valid && ev_line == acc_line);
    assign acc_go   = acc_valid && !acc_busy;
    assign start    = acc_go && cm;
    assign upd_en   = acc_go && !cm;
    assign upd_data = apply_acc((st == ST_FILL) ? idle_line() : rd_acc,
                                acc_write, acc_word);

    always_comb begin
        fill_base        = rd_pend;
        fill_base.wr_oth = hq_rsp_wr_oth;
        fill_base.rd_oth = hq_rsp_rd_oth;
        fill_base.pc     = pend_pc;
        fill_base.coh    = 1'b1;
        fill_base.fs     = 1'b1;
    end
    assign fill_data = apply_acc(fill_base, pend_wr, pend_word);

    assign ev_ready = !rec_valid && !(pend_valid && pend_line == ev_line);
    assign ev_go    = ev_valid && ev_ready;
    assign rec_load = ev_go && rd_ev.coh;

    shc_line_bank #(.NUM_LINES(NUM_LINES)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en),
        .upd_idx   (acc_line),
        .upd_data  (upd_data),
        .fill_en   (q_done),
        .fill_idx  (pend_line),
        .fill_data (fill_data),
        .clr_en    (ev_go),
        .clr_idx   (ev_line),
        .rd_a_idx  (acc_line),
        .rd_b_idx  (pend_line),
        .rd_c_idx  (ev_line),
        .rd_a      (rd_acc),
        .rd_b      (rd_pend),
        .rd_c      (rd_ev)
    );

    shc_query_track #(.LINE_W(LINE_W)) u_query (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_line (acc_line),
        .start_wr   (acc_write),
        .start_word (acc_word),
        .start_pc   (acc_pc),
        .rsp_valid  (hq_rsp_valid),
        .pend_valid (pend_valid),
        .pend_line  (pend_line),
        .pend_wr    (pend_wr),
        .pend_word  (pend_word),
        .pend_pc    (pend_pc),
        .req_valid  (hq_req_valid),
        .done       (q_done)
    );
    assign hq_req_line = pend_line;

    shc_rec_buf u_rec (
        .clk       (clk),
        .rst       (rst),
        .load      (rec_load),
        .load_pc   (rd_ev.pc),
        .load_fs   (rd_ev.fs),
        .rec_ready (rec_ready),
        .rec_valid (rec_valid),
        .rec_pc    (rec_pc),
        .rec_false (rec_false)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            push_valid  <= 1'b0;
            push_line   <= '0;
            push_loc_wr <= '0;
            push_loc_rd <= '0;
        end else begin
            push_valid <= ev_go;
            if (ev_go) begin
                push_line   <= ev_line;
                push_loc_wr <= rd_ev.loc_wr;
                push_loc_rd <= rd_ev.loc_rd;
            end
        end
    end

endmodule

// File: rtl/shc_checker.sv
module shc_checker
    import shc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 8,
    localparam int unsigned LINE_W = $clog2(NUM_LINES)
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [LINE_W-1:0] acc_line,
    input logic              acc_busy,
    input logic              hq_req_valid,
    input logic [LINE_W-1:0] hq_req_line,
    input logic              hq_rsp_valid,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [LINE_W-1:0] ev_line,
    input logic              push_valid,
    input logic [LINE_W-1:0] push_line,
    input logic              rec_valid,
    input logic              rec_ready,
    input logic [PC_W-1:0]   rec_pc,
    input logic              rec_false
);

    logic              chk_pend;
    logic [LINE_W-1:0] chk_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_pend <= 1'b0;
            chk_line <= '0;
        end else if (hq_rsp_valid) begin
            chk_pend <= 1'b0;
        end else if (hq_req_valid) begin
            chk_pend <= 1'b1;
            chk_line <= hq_req_line;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !rec_valid && !push_valid && !hq_req_valid);

    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        hq_req_valid |=> !hq_req_valid);

    // R3
    pend_stall_chk: assert property (@(posedge clk) disable iff (rst)
        chk_pend && acc_valid && acc_line == chk_line |-> acc_busy);

    // R8
    push_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ev_valid && ev_ready |=> push_valid && push_line == $past(ev_line));

    // R9
    rec_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid) |-> $past(ev_valid && ev_ready));

    // R10
    rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_pc) && $stable(rec_false));

    // R10
    ev_block_chk: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> !ev_ready);

endmodule

bind shc_top shc_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_line     (acc_line),
    .acc_busy     (acc_busy),
    .hq_req_valid (hq_req_valid),
    .hq_req_line  (hq_req_line),
    .hq_rsp_valid (hq_rsp_valid),
    .ev_valid     (ev_valid),
    .ev_ready     (ev_ready),
    .ev_line      (ev_line),
    .push_valid   (push_valid),
    .push_line    (push_line),
    .rec_valid    (rec_valid),
    .rec_ready    (rec_ready),
    .rec_pc       (rec_pc),
    .rec_false    (rec_false)
);

// File: tb/tb_shc_top.sv
module tb_shc_top;
    import shc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 8;
    localparam int LW = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_valid = 1'b0, acc_write = 1'b0;
    logic [LW-1:0]     acc_line = '0;
    logic [WORD_W-1:0] acc_word = '0;
    logic [PC_W-1:0]   acc_pc = '0;
    logic [1:0]        acc_state = 2'b00;
    logic              acc_busy;
    logic              hq_req_valid;
    logic [LW-1:0]     hq_req_line;
    logic              hq_rsp_valid = 1'b0;
    logic [WORDS-1:0]  hq_rsp_wr_oth = '0, hq_rsp_rd_oth = '0;
    logic              ev_valid = 1'b0;
    logic [LW-1:0]     ev_line = '0;
    logic              ev_ready, push_valid;
    logic [LW-1:0]     push_line;
    logic [WORDS-1:0]  push_loc_wr, push_loc_rd;
    logic              rec_valid, rec_false;
    logic              rec_ready = 1'b0;
    logic [PC_W-1:0]   rec_pc;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shc_top #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_line(acc_line),
        .acc_word(acc_word), .acc_pc(acc_pc), .acc_state(acc_state),
        .acc_busy(acc_busy),
        .hq_req_valid(hq_req_valid), .hq_req_line(hq_req_line),
        .hq_rsp_valid(hq_rsp_valid), .hq_rsp_wr_oth(hq_rsp_wr_oth),
        .hq_rsp_rd_oth(hq_rsp_rd_oth),
        .ev_valid(ev_valid), .ev_line(ev_line), .ev_ready(ev_ready),
        .push_valid(push_valid), .push_line(push_line),
        .push_loc_wr(push_loc_wr), .push_loc_rd(push_loc_rd),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_pc(rec_pc), .rec_false(rec_false)
    );

    task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WORDS-1:0] bit_of(int k);
        return WORDS'(1) << k;
    endfunction

    // plain access, accepted in one cycle
    task automatic access(int line, bit wr, int word, int pc, logic [1:0] st);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_line = LW'(line);
        acc_word = WORD_W'(word); acc_pc = PC_W'(pc); acc_state = st;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R2", "no query on non-coherence access", hq_req_valid, 0);
    endtask

    // coherence miss, query, busy probe, response in the request cycle
    task automatic miss(int line, bit wr, int word, int pc, logic [1:0] st,
                        logic [WORDS-1:0] wm, logic [WORDS-1:0] rm);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_line = LW'(line);
        acc_word = WORD_W'(word); acc_pc = PC_W'(pc); acc_state = st;
        @(posedge clk);
        @(negedge clk);
        chk("R3", "query pulse", hq_req_valid, 1);
        chk("R3", "query line", hq_req_line, line);
        acc_write = 1'b0; acc_state = 2'b00;
        #1;
        chk("R3", "busy on pending line", acc_busy, 1);
        acc_valid = 1'b0;
        hq_rsp_valid = 1'b1; hq_rsp_wr_oth = wm; hq_rsp_rd_oth = rm;
        @(posedge clk);
        @(negedge clk);
        hq_rsp_valid = 1'b0;
        chk("R3", "query pulse ends", hq_req_valid, 0);
        #1;
        chk("R3", "busy released", acc_busy, 0);
    endtask

    task automatic evict(string req, int line, logic [WORDS-1:0] ewr, logic [WORDS-1:0] erd,
                         bit erec, int epc, bit efs, bit accept);
        @(negedge clk);
        chk(req, "ev_ready before eviction", ev_ready, 1);
        ev_valid = 1'b1; ev_line = LW'(line);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        chk("R8", "push_valid", push_valid, 1);
        chk("R8", "push_line", push_line, line);
        chk(req, "push_loc_wr", push_loc_wr, ewr);
        chk(req, "push_loc_rd", push_loc_rd, erd);
        chk(req, "rec_valid", rec_valid, erec);
        if (erec) begin
            chk("R4", "rec_pc", rec_pc, epc);
            chk(req, "rec_false", rec_false, efs);
            if (accept) begin
                rec_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                rec_ready = 1'b0;
                chk("R10", "record taken", rec_valid, 0);
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "rec_valid", rec_valid, 0);
        chk("R1", "push_valid", push_valid, 0);
        chk("R1", "hq_req_valid", hq_req_valid, 0);
        chk("R1", "acc_busy", acc_busy, 0);
        chk("R1", "ev_ready", ev_ready, 1);
    endtask

    // write miss stays false: missing word and later reads touch nothing produced elsewhere
    task automatic t_false_write();
        miss(1, 1'b1, 3, 16'h1234, 2'b01, bit_of(5), bit_of(9));
        access(1, 1'b0, 4, 16'h1240, 2'b00);
        access(1, 1'b0, 9, 16'h1244, 2'b00);   // R6 read of word only read by others
        evict("R6", 1, bit_of(3), bit_of(4) | bit_of(9), 1'b1, 16'h1234, 1'b1, 1'b1);
        evict("R11", 1, '0, '0, 1'b0, 0, 1'b0, 1'b0);
    endtask

    // write miss in read-only state hits a word read by others
    task automatic t_true_write_ro();
        miss(2, 1'b1, 2, 16'h2222, 2'b10, '0, bit_of(2));
        evict("R5", 2, bit_of(2), '0, 1'b1, 16'h2222, 1'b0, 1'b1);
    endtask

    // read miss stays false, later hit on a produced word flips it
    task automatic t_late_flip();
        miss(3, 1'b0, 6, 16'h3333, 2'b01, bit_of(7), bit_of(6));
        access(3, 1'b0, 7, 16'h3340, 2'b00);
        access(3, 1'b1, 6, 16'h3344, 2'b00);   // R8 write clears local read bit
        evict("R7", 3, bit_of(6), bit_of(7), 1'b1, 16'h3333, 1'b0, 1'b1);
    endtask

    // read in read-only state is a hit; write hit is no miss either
    task automatic t_no_miss();
        access(4, 1'b0, 1, 16'h4444, 2'b10);
        access(4, 1'b1, 8, 16'h4448, 2'b00);
        evict("R9", 4, bit_of(8), bit_of(1), 1'b0, 0, 1'b0, 1'b0);
    endtask

    // refill erases a classified residency
    task automatic t_refill();
        miss(5, 1'b1, 0, 16'h5555, 2'b01, bit_of(0), '0);
        access(5, 1'b0, 9, 16'h5560, 2'b11);
        evict("R11", 5, '0, bit_of(9), 1'b0, 0, 1'b0, 1'b0);
    endtask

    // held record blocks evictions and stays stable
    task automatic t_hold();
        miss(6, 1'b0, 12, 16'h6666, 2'b01, '0, '0);
        evict("R10", 6, '0, bit_of(12), 1'b1, 16'h6666, 1'b1, 1'b0);
        ev_line = LW'(7);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10", "record held", rec_valid, 1);
            chk("R10", "pc held", rec_pc, 16'h6666);
            chk("R10", "eviction blocked", ev_ready, 0);
        end
        rec_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rec_ready = 1'b0;
        chk("R10", "record released", rec_valid, 0);
        chk("R10", "ev_ready back", ev_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_false_write();
        t_true_write_ro();
        t_late_flip();
        t_no_miss();
        t_refill();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule